// File: doc/BRIEF.md
# Parallel LCD bus controller

This block sits between a small register interface on a microcontroller and an external character or graphic LCD controller wired over an 8-bit parallel bus. Firmware programs a control register, then writes the data register to send one byte, or sets a read-command bit to fetch one byte of LCD data or LCD status. The control register selects the level of the register-select pin for the access, the bus style (E plus R/W strobing, or separate active-low read and write strobes) and the cycle shape (normalized 2/4/2 clock phases, or non-normalized 1/2/1 phases).

A programmable 8-bit mask can turn on busy polling. When the mask is nonzero, every access is preceded by status reads with register-select low, and these repeat until the status byte ANDed with the mask is zero. A busy flag in the status register is set for the whole sequence. The LCD data bus is split into an output, an output enable and an input. Off-chip these form the bidirectional bus.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: After reset all four host registers read 0x00. The bus is idle: E low, R/W high, RD_n and WR_n high, and the data output enable low.
- R2: While the enable bit (control bit 2) is clear, neither a data-register write nor a read command starts a bus cycle. A data write leaves the data register unchanged, and the read-command bit (control bit 1) stays 0.
- R3: With enable set and the block not busy, a data-register write starts one LCD write. That write drives the written byte, puts control bit 0 on the RS pin, and holds the output enable high for the whole access.
- R4: Writing the control register with bits 1 and 2 set starts one LCD read, with RS taken from bit 0 of that write. When the read ends, bit 1 clears and the data register holds the byte sampled in the last strobe clock.
- R5: Control bit 3 clear gives setup, strobe and hold phases of 2, 4 and 2 clocks. Bit 3 set gives 1, 2 and 1 clocks. A write therefore drives the bus for 8 or 4 clocks, and the strobe lasts 4 or 2 clocks.
- R6: Control bit 4 clear selects E/RW signalling: E is high during the strobe phase, and R/W is high for reads and low for writes. Bit 4 set selects RD_n/WR_n signalling: the matching strobe is low during the strobe phase and E stays low. The data bus is driven only during writes.
- R7: Status register bit 0 is the busy flag, and bits 7:1 read 0. Busy rises in the clock after an access is accepted, and it stays high until the access ends, busy polling included.
- R8: When the mask register is nonzero, each access is preceded by status reads with RS low. These repeat while (status AND mask) is nonzero, and the queued access starts after the first zero result. Status bits outside the mask are ignored. A zero mask gives no polling.
- R9: A data-register write while busy is ignored. The data register keeps its value and no extra bus cycle runs.
- R10: The host register addresses are 0 for control, 1 for status, 2 for mask and 3 for data. host_rdata shows the addressed register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| lcd_rs | output | 1 | Register-select / A0 pin |
| lcd_e | output | 1 | Enable strobe, E/RW mode |
| lcd_rw | output | 1 | Read/write direction, E/RW mode |
| lcd_rd_n | output | 1 | Active-low read strobe, RD_n/WR_n mode |
| lcd_wr_n | output | 1 | Active-low write strobe, RD_n/WR_n mode |
| lcd_dout | output | 8 | Data bus output |
| lcd_doe | output | 1 | Data bus output enable |
| lcd_din | input | 8 | Data bus input |

## Verification
The hardest state to reach from the ports is a poll loop that repeats a set number of times and then releases the queued write. The LCD model in the bench returns a status byte with the masked bit set. The bus monitor counts the status reads it observes and clears that bit right after the strobe of the second poll, so exactly three polls come before the write. A second case sets every status bit except the masked one, which shows that unmasked bits do not hold the access back. A data write issued during an access confirms that the ignored write starts no extra bus cycle.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int DW = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  localparam int B_RS   = 0;
  localparam int B_RD   = 1;
  localparam int B_EN   = 2;
  localparam int B_FAST = 3;
  localparam int B_I80  = 4;
  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;
  typedef enum logic [1:0] {CS_IDLE, CS_POLL, CS_ACC} cstate_t;

  typedef struct packed {
    logic          rd;
    logic          rs;
    logic          fast;
    logic          i80;
    logic [DW-1:0] wd;
  } attr_t;
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer
  import lcd_pkg::*;
#(
  parameter int SETUP_N  = 2,
  parameter int STROBE_N = 4,
  parameter int HOLD_N   = 2,
  parameter int SETUP_F  = 1,
  parameter int STROBE_F = 2,
  parameter int HOLD_F   = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  attr_t  attr_i,
  output phase_t phase_d,
  output attr_t  attr_d,
  output logic   sample,
  output logic   done
);
  localparam int MAX_A = (SETUP_N > STROBE_N) ? SETUP_N : STROBE_N;
  localparam int MAX_B = (HOLD_N > MAX_A) ? HOLD_N : MAX_A;
  localparam int MAXN  = MAX_B;
  localparam int CW    = (MAXN < 2) ? 1 : $clog2(MAXN);

  phase_t        phase_q;
  attr_t         attr_q;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [CW-1:0] span(phase_t ph, logic fast);
    case (ph)
      PH_SETUP:  span = fast ? CW'(SETUP_F - 1)  : CW'(SETUP_N - 1);
      PH_STROBE: span = fast ? CW'(STROBE_F - 1) : CW'(STROBE_N - 1);
      default:   span = fast ? CW'(HOLD_F - 1)   : CW'(HOLD_N - 1);
    endcase
  endfunction

  assign done   = (phase_q == PH_HOLD)   && (cnt_q == '0);
  assign sample = (phase_q == PH_STROBE) && (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    attr_d  = attr_q;
    if (start && (phase_q == PH_IDLE || done)) begin
      phase_d = PH_SETUP;
      attr_d  = attr_i;
      cnt_d   = span(PH_SETUP, attr_i.fast);
    end else if (phase_q != PH_IDLE) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        case (phase_q)
          PH_SETUP: begin
            phase_d = PH_STROBE;
            cnt_d   = span(PH_STROBE, attr_q.fast);
          end
          PH_STROBE: begin
            phase_d = PH_HOLD;
            cnt_d   = span(PH_HOLD, attr_q.fast);
          end
          default: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      attr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      attr_q  <= attr_d;
    end
  end
endmodule

// File: rtl/lcd_pin_drv.sv
module lcd_pin_drv
  import lcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase_d,
  input  logic          rd_i,
  input  logic          rs_i,
  input  logic          i80_i,
  input  logic [DW-1:0] wd_i,
  output logic          lcd_rs,
  output logic          lcd_e,
  output logic          lcd_rw,
  output logic          lcd_rd_n,
  output logic          lcd_wr_n,
  output logic [DW-1:0] lcd_dout,
  output logic          lcd_doe
);
  logic act, strobe;
  assign act    = (phase_d != PH_IDLE);
  assign strobe = (phase_d == PH_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_rs   <= 1'b0;
      lcd_e    <= 1'b0;
      lcd_rw   <= 1'b1;
      lcd_rd_n <= 1'b1;
      lcd_wr_n <= 1'b1;
      lcd_dout <= '0;
      lcd_doe  <= 1'b0;
    end else begin
      if (act) begin
        lcd_rs   <= rs_i;
        lcd_dout <= wd_i;
      end
      lcd_e    <= !i80_i && strobe;
      lcd_rw   <= !(act && !i80_i && !rd_i);
      lcd_rd_n <= !(i80_i && strobe && rd_i);
      lcd_wr_n <= !(i80_i && strobe && !rd_i);
      lcd_doe  <= act && !rd_i;
    end
  end
endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_rd,
  input  logic          req_rs,
  input  logic [DW-1:0] req_wd,
  input  logic          cfg_fast,
  input  logic          cfg_i80,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] cap,
  input  logic          done,
  output logic          start,
  output attr_t         attr_o,
  output logic          busy,
  output logic          fin,
  output logic          fin_rd
);
  cstate_t       state_q, state_d;
  logic          p_rd, p_rs;
  logic [DW-1:0] p_wd;

  function automatic attr_t mk(logic rd, logic rs, logic [DW-1:0] wd,
                               logic fast, logic i80);
    attr_t a;
    a.rd   = rd;
    a.rs   = rs;
    a.fast = fast;
    a.i80  = i80;
    a.wd   = wd;
    return a;
  endfunction

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    fin     = 1'b0;
    attr_o  = mk(p_rd, p_rs, p_wd, cfg_fast, cfg_i80);
    case (state_q)
      CS_IDLE: if (req) begin
        start = 1'b1;
        if (|mask) begin
          attr_o  = mk(1'b1, 1'b0, req_wd, cfg_fast, cfg_i80);
          state_d = CS_POLL;
        end else begin
          attr_o  = mk(req_rd, req_rs, req_wd, cfg_fast, cfg_i80);
          state_d = CS_ACC;
        end
      end
      CS_POLL: if (done) begin
        start = 1'b1;
        if (|(cap & mask)) begin
          attr_o = mk(1'b1, 1'b0, p_wd, cfg_fast, cfg_i80);
        end else begin
          state_d = CS_ACC;
        end
      end
      default: if (done) begin
        fin     = 1'b1;
        state_d = CS_IDLE;
      end
    endcase
  end

  assign busy   = (state_q != CS_IDLE);
  assign fin_rd = p_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CS_IDLE;
      p_rd    <= 1'b0;
      p_rs    <= 1'b0;
      p_wd    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == CS_IDLE && req) begin
        p_rd <= req_rd;
        p_rs <= req_rs;
        p_wd <= req_wd;
      end
    end
  end
endmodule

// File: rtl/lcd_regs.sv
module lcd_regs
  import lcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          busy,
  input  logic          fin,
  input  logic          fin_rd,
  input  logic [DW-1:0] cap,
  output logic          req,
  output logic          req_rd,
  output logic          req_rs,
  output logic          cfg_fast,
  output logic          cfg_i80,
  output logic [DW-1:0] mask,
  output logic          ctrl_en,
  output logic          ctrl_rd
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     data_q;
  logic              ctrl_wr, data_wr, req_wr;

  assign ctrl_wr  = host_we && (host_addr == A_CTRL);
  assign data_wr  = host_we && (host_addr == A_DATA);
  assign req_wr   = data_wr && ctrl_q[B_EN] && !busy;
  assign req_rd   = ctrl_wr && host_wdata[B_RD] && host_wdata[B_EN] && !busy;
  assign req      = req_wr || req_rd;
  assign req_rs   = ctrl_wr ? host_wdata[B_RS]   : ctrl_q[B_RS];
  assign cfg_fast = ctrl_wr ? host_wdata[B_FAST] : ctrl_q[B_FAST];
  assign cfg_i80  = ctrl_wr ? host_wdata[B_I80]  : ctrl_q[B_I80];
  assign ctrl_en  = ctrl_q[B_EN];
  assign ctrl_rd  = ctrl_q[B_RD];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      mask       <= '0;
      data_q     <= '0;
      host_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q[B_RS]   <= host_wdata[B_RS];
        ctrl_q[B_EN]   <= host_wdata[B_EN];
        ctrl_q[B_FAST] <= host_wdata[B_FAST];
        ctrl_q[B_I80]  <= host_wdata[B_I80];
        if (!busy) ctrl_q[B_RD] <= host_wdata[B_RD] && host_wdata[B_EN];
      end
      if (host_we && host_addr == A_MASK) mask <= host_wdata;
      if (req_wr) data_q <= host_wdata;
      if (fin && fin_rd) begin
        ctrl_q[B_RD] <= 1'b0;
        data_q       <= cap;
      end
      case (host_addr)
        A_CTRL:  host_rdata <= {{(DW-CTRL_W){1'b0}}, ctrl_q};
        A_STAT:  host_rdata <= {{(DW-1){1'b0}}, busy};
        A_MASK:  host_rdata <= mask;
        default: host_rdata <= data_q;
      endcase
    end
  end
endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcd_pkg::*;
#(
  parameter int SETUP_N  = 2,
  parameter int STROBE_N = 4,
  parameter int HOLD_N   = 2,
  parameter int SETUP_F  = 1,
  parameter int STROBE_F = 2,
  parameter int HOLD_F   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          lcd_rs,
  output logic          lcd_e,
  output logic          lcd_rw,
  output logic          lcd_rd_n,
  output logic          lcd_wr_n,
  output logic [DW-1:0] lcd_dout,
  output logic          lcd_doe,
  input  logic [DW-1:0] lcd_din
);
  logic          req, req_rd, req_rs, cfg_fast, cfg_i80;
  logic [DW-1:0] mask, cap;
  logic          ctrl_en, ctrl_rd;
  logic          busy, fin, fin_rd, start, sample, done;
  attr_t         seq_attr, tm_attr_d;
  phase_t        tm_phase_d;

  lcd_regs u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .fin(fin), .fin_rd(fin_rd), .cap(cap), .req(req), .req_rd(req_rd),
    .req_rs(req_rs), .cfg_fast(cfg_fast), .cfg_i80(cfg_i80), .mask(mask),
    .ctrl_en(ctrl_en), .ctrl_rd(ctrl_rd)
  );

  lcd_seq_ctrl u_seq (
    .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_rs(req_rs),
    .req_wd(host_wdata), .cfg_fast(cfg_fast), .cfg_i80(cfg_i80),
    .mask(mask), .cap(cap), .done(done), .start(start), .attr_o(seq_attr),
    .busy(busy), .fin(fin), .fin_rd(fin_rd)
  );

  lcd_phase_timer #(
    .SETUP_N(SETUP_N), .STROBE_N(STROBE_N), .HOLD_N(HOLD_N),
    .SETUP_F(SETUP_F), .STROBE_F(STROBE_F), .HOLD_F(HOLD_F)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start), .attr_i(seq_attr),
    .phase_d(tm_phase_d), .attr_d(tm_attr_d), .sample(sample), .done(done)
  );

  lcd_pin_drv u_pins (
    .clk(clk), .rst(rst), .phase_d(tm_phase_d), .rd_i(tm_attr_d.rd),
    .rs_i(tm_attr_d.rs), .i80_i(tm_attr_d.i80), .wd_i(tm_attr_d.wd),
    .lcd_rs(lcd_rs), .lcd_e(lcd_e), .lcd_rw(lcd_rw), .lcd_rd_n(lcd_rd_n),
    .lcd_wr_n(lcd_wr_n), .lcd_dout(lcd_dout), .lcd_doe(lcd_doe)
  );

  always_ff @(posedge clk) begin
    if (rst)         cap <= '0;
    else if (sample) cap <= lcd_din;
  end
endmodule

// File: rtl/lcd_bus_chk.sv
module lcd_bus_chk
  import lcd_pkg::*;
#(
  parameter int STROBE_N = 4,
  parameter int STROBE_F = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       host_we,
  input logic [1:0] host_addr,
  input logic       lcd_e,
  input logic       lcd_rw,
  input logic       lcd_rd_n,
  input logic       lcd_wr_n,
  input logic       lcd_doe,
  input logic       ctrl_en,
  input logic       ctrl_rd,
  input logic       busy,
  input logic       fast
);
  logic strobe;
  int   scnt;
  assign strobe = lcd_e || !lcd_rd_n || !lcd_wr_n;

  always_ff @(posedge clk) begin
    if (rst) scnt <= 0;
    else     scnt <= strobe ? scnt + 1 : 0;
  end

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lcd_e && (!lcd_rd_n || !lcd_wr_n)) && !(!lcd_rd_n && !lcd_wr_n));

  // R3
  write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_doe |-> (lcd_rd_n && !(lcd_e && lcd_rw)));

  // R7
  pin_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_doe || strobe) |-> busy);

  // R2
  disabled_start_chk: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == A_DATA && !ctrl_en && !busy) |=> !busy);

  // R4
  rdcmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |-> busy);

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> (scnt == (fast ? STROBE_F : STROBE_N)));
endmodule

bind lcd_bus_ctrl lcd_bus_chk #(.STROBE_N(STROBE_N), .STROBE_F(STROBE_F)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .lcd_e(lcd_e), .lcd_rw(lcd_rw), .lcd_rd_n(lcd_rd_n), .lcd_wr_n(lcd_wr_n),
  .lcd_doe(lcd_doe), .ctrl_en(ctrl_en), .ctrl_rd(ctrl_rd), .busy(busy),
  .fast(tm_attr_d.fast)
);

// File: tb/test_lcd_bus_ctrl.sv
module test_lcd_bus_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_we = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       lcd_rs, lcd_e, lcd_rw, lcd_rd_n, lcd_wr_n, lcd_doe;
  logic [7:0] lcd_dout, lcd_din;
  logic [7:0] lcd_stat = 8'h00;
  logic [7:0] lcd_rdval = 8'h00;

  always #4 clk = ~clk;

  assign lcd_din = lcd_rs ? lcd_rdval : lcd_stat;

  lcd_bus_ctrl i_lcd_bus_ctrl (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .lcd_rs(lcd_rs),
    .lcd_e(lcd_e), .lcd_rw(lcd_rw), .lcd_rd_n(lcd_rd_n), .lcd_wr_n(lcd_wr_n),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
  );

  typedef struct {
    bit         rd;
    bit         rs;
    logic [7:0] data;
    int         width;
    int         doe_len;
  } item_t;

  item_t expq[$];
  int    checks = 0;
  int    errors = 0;
  int    polls_seen = 0;
  int    release_at = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver side of the scoreboard
  task automatic exp_push(input bit rd, input bit rs, input logic [7:0] d,
                          input bit fast);
    item_t it;
    it.rd      = rd;
    it.rs      = rs;
    it.data    = d;
    it.width   = fast ? 2 : 4;
    it.doe_len = rd ? 0 : (fast ? 4 : 8);
    expq.push_back(it);
  endtask

  // monitor side of the scoreboard
  logic  m_strb;
  logic  strb_p = 1'b0;
  logic  doe_p = 1'b0;
  int    swid = 0;
  int    dwid = 0;
  int    last_doe = 0;
  item_t got;
  item_t ex;

  always @(negedge clk) begin
    if (!rst) begin
      m_strb = lcd_e | ~lcd_rd_n | ~lcd_wr_n;
      if (lcd_e && (!lcd_rd_n || !lcd_wr_n)) begin
        checks++;
        errors++;
        $display("FAIL R6 mixed strobes: actual %0b%0b%0b expected 100 or 011",
                 lcd_e, lcd_rd_n, lcd_wr_n);
      end
      if (m_strb) begin
        if (!strb_p) begin
          got.rd   = lcd_e ? lcd_rw : ~lcd_rd_n;
          got.rs   = lcd_rs;
          got.data = lcd_dout;
        end
        swid++;
      end else if (strb_p) begin
        got.width = swid;
        swid = 0;
        if (expq.size() == 0) begin
          check(1'b0, "R2/R9", "unexpected bus cycle", {got.rd, got.rs, got.data}, 0);
        end else begin
          ex = expq.pop_front();
          check(got.rd == ex.rd && got.rs == ex.rs && got.width == ex.width &&
                (ex.rd || got.data == ex.data),
                "R3/R4/R5/R6/R8", "bus cycle {rd,rs,data,width}",
                {got.rd, got.rs, got.data, got.width[7:0]},
                {ex.rd, ex.rs, ex.rd ? got.data : ex.data, ex.width[7:0]});
          last_doe = ex.doe_len;
          if (ex.rd && !ex.rs) begin
            polls_seen++;
            if (release_at != 0 && polls_seen == release_at) lcd_stat = 8'h00;
          end
        end
      end
      if (lcd_doe) begin
        dwid++;
      end else if (doe_p) begin
        check(dwid == last_doe, "R5", "write drive length", dwid, last_doe);
        dwid = 0;
      end
      strb_p = m_strb;
      doe_p  = lcd_doe;
    end
  end

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we    = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    bit idle = 1'b0;
    for (int i = 0; i < 300 && !idle; i++) begin
      hread(2'd1, v);
      if (v[0] == 1'b0) idle = 1'b1;
    end
    check(idle, "R7", "busy never cleared", 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(!lcd_e && lcd_rw && lcd_rd_n && lcd_wr_n && !lcd_doe, "R1", "idle pins",
          {lcd_e, lcd_rw, lcd_rd_n, lcd_wr_n, lcd_doe}, 5'b01110);
    for (int a = 0; a < 4; a++) begin
      hread(a[1:0], v);
      check(v == 8'h00, "R1/R10", "register after reset", v, 0);
    end

    // R2 disabled: no access starts
    hwrite(2'd3, 8'h33);
    repeat (20) @(negedge clk);
    hread(2'd3, v);
    check(v == 8'h00, "R2", "data reg while disabled", v, 0);
    hread(2'd1, v);
    check(v == 8'h00, "R2", "status while disabled", v, 0);
    hwrite(2'd0, 8'h02);
    repeat (20) @(negedge clk);
    hread(2'd0, v);
    check(v == 8'h00, "R2", "read command while disabled", v, 0);

    // R3 R5 R6 R7: normalized write, E/RW style
    hwrite(2'd0, 8'h05);
    exp_push(1'b0, 1'b1, 8'h5A, 1'b0);
    hwrite(2'd3, 8'h5A);
    hread(2'd1, v);
    check(v == 8'h01, "R7", "status during write", v, 1);
    wait_idle();
    hread(2'd1, v);
    check(v == 8'h00, "R7", "status after write", v, 0);

    // R9: write while busy is ignored
    exp_push(1'b0, 1'b1, 8'h11, 1'b0);
    hwrite(2'd3, 8'h11);
    hwrite(2'd3, 8'h22);
    wait_idle();
    hread(2'd3, v);
    check(v == 8'h11, "R9", "data reg after busy write", v, 8'h11);

    // R5 R6: fast write, RD_n/WR_n style, RS low
    hwrite(2'd0, 8'h1C);
    exp_push(1'b0, 1'b0, 8'hC3, 1'b1);
    hwrite(2'd3, 8'hC3);
    wait_idle();
    hread(2'd3, v);
    check(v == 8'hC3, "R3", "data reg after write", v, 8'hC3);

    // R4: normalized read of LCD data, E/RW style
    lcd_rdval = 8'hA5;
    exp_push(1'b1, 1'b1, 8'h00, 1'b0);
    hwrite(2'd0, 8'h07);
    wait_idle();
    hread(2'd3, v);
    check(v == 8'hA5, "R4", "data reg after read", v, 8'hA5);
    hread(2'd0, v);
    check(v == 8'h05, "R4", "read bit cleared", v, 8'h05);

    // R4 R6: fast status read, RD_n/WR_n style
    lcd_stat = 8'h3C;
    exp_push(1'b1, 1'b0, 8'h00, 1'b1);
    hwrite(2'd0, 8'h1E);
    wait_idle();
    hread(2'd3, v);
    check(v == 8'h3C, "R4", "data reg after status read", v, 8'h3C);
    hread(2'd0, v);
    check(v == 8'h1C, "R4", "read bit cleared fast", v, 8'h1C);

    // R8: polling repeats until the masked bit clears
    hwrite(2'd0, 8'h05);
    hwrite(2'd2, 8'h80);
    hread(2'd2, v);
    check(v == 8'h80, "R10", "mask readback", v, 8'h80);
    lcd_stat   = 8'h80;
    release_at = polls_seen + 2;
    exp_push(1'b1, 1'b0, 8'h00, 1'b0);
    exp_push(1'b1, 1'b0, 8'h00, 1'b0);
    exp_push(1'b1, 1'b0, 8'h00, 1'b0);
    exp_push(1'b0, 1'b1, 8'h99, 1'b0);
    hwrite(2'd3, 8'h99);
    hread(2'd1, v);
    check(v == 8'h01, "R8", "busy while polling", v, 1);
    wait_idle();
    release_at = 0;

    // R8: unmasked status bits do not hold the access
    lcd_stat = 8'h7F;
    exp_push(1'b1, 1'b0, 8'h00, 1'b0);
    exp_push(1'b0, 1'b1, 8'h42, 1'b0);
    hwrite(2'd3, 8'h42);
    wait_idle();

    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R8", "expected cycles left", expq.size(), 0);
    finish_run();
  end
endmodule